// File: doc/BRIEF.md
# Pruned Parallel-Prefix Adder (8-bit)

This block adds two 8-bit operands and a carry-in and returns an 8-bit sum and a carry-out. It is purely combinational: no clock, no state. Inside, it has three parts. A per-bit stage forms propagate and generate terms. A three-level prefix tree turns them into carries. A final stage forms the sum bits. It is intended for fast datapaths, such as partial-product accumulation, where the carry path sets the cycle time.

The prefix tree follows the full-fan-out Kogge-Stone pattern, but three combining cells that compute both propagate and generate have been taken out, for the spans 2:1, 4:1 and 5:2. Their consumers now take other existing group signals instead. This is valid because a prefix ending at bit i may overlap a lower span it has already covered, provided it never reaches above bit i. The tree depth stays at three levels. The carry-in is merged into bit 0's generate term, so every prefix that ends at bit 0 already includes it.

Top module: `ksp_adder`

## Requirements
- R1: Bit i contributes propagate = a[i] XOR b[i] and generate = a[i] AND b[i]. A single set bit in one operand, with the other operand zero and cin=0, appears unchanged in the sum.
- R2: `sum` equals bits 7..0 of a + b + cin for every input combination.
- R3: `cout` equals bit 8 of a + b + cin for every input combination.
- R4: With both operands zero, `sum` equals cin in bit 0 and zeros elsewhere, and `cout` is 0.
- R5: When a XOR b is all ones, the carry passes through every bit: cin=0 gives sum 8'hFF with cout 0, and cin=1 gives sum 8'h00 with cout 1.
- R6: A bit with a[i]=b[i]=1 forces a carry into bit i+1, or into cout when i=7, whatever the lower bits are.
- R7: A bit with a[i]=b[i]=0 stops the carry: the carry into bit i+1, or cout when i=7, is 0.
- R8: The outputs follow any input change with no clock edge.
- R9: 8'b11111110 + 8'b11111111 with cin=0 gives sum 8'b11111101 and cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 8 | Sum bits 7..0 |
| cout | output | 1 | Carry out of bit 7 |

## Verification
The assertions in the top module check, whenever the inputs change, that the sum and carry-out match a reference addition. They also check that a generating bit always passes a carry upward, that a killing bit always blocks it, and that an all-propagate operand pair passes cin straight to cout. Only the bench's scenarios can show that the outputs settle without any clock edge and that the pruned network is correct over the whole input space. For the second point, the bench applies every operand and carry-in combination and compares the results with its own arithmetic.

// File: rtl/ksp_pkg.sv
package ksp_pkg;

    localparam int ADDER_W    = 8;
    localparam int PFX_LEVELS = $clog2(ADDER_W);

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    function automatic pg_t pg_combine(input pg_t hi, input pg_t lo);
        pg_t r;
        r.p = hi.p & lo.p;
        r.g = hi.g | (hi.p & lo.g);
        return r;
    endfunction

endpackage

// File: rtl/ksp_pre.sv
module ksp_pre
    import ksp_pkg::*;
#(
    parameter int W = ADDER_W
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output pg_t  [W-1:0] bit_pg
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_pg[i].p = a_in[i] ^ b_in[i];
        assign bit_pg[i].g = a_in[i] & b_in[i];
    end
endmodule

// File: rtl/ksp_black_cell.sv
module ksp_black_cell
    import ksp_pkg::*;
(
    input  pg_t upper,
    input  pg_t lower,
    output pg_t span
);
    assign span = pg_combine(upper, lower);
endmodule

// File: rtl/ksp_grey_cell.sv
module ksp_grey_cell
    import ksp_pkg::*;
(
    input  pg_t  upper,
    input  logic lower_g,
    output logic span_g
);
    assign span_g = upper.g | (upper.p & lower_g);
endmodule

// File: rtl/ksp_prefix_net.sv
module ksp_prefix_net
    import ksp_pkg::*;
(
    input  pg_t  [ADDER_W-1:0] bit_pg,
    input  logic               cin,
    output logic [ADDER_W-1:0] pfx_g
);
    // pfx_g[i] is the group generate of span i:0, carry-in included.
    // lvl1[i] holds span i:i-1. Span 2:1 is pruned, so index 2 is unused.
    pg_t [ADDER_W-1:0] lvl1;
    pg_t span_6_3, span_7_4;

    // Bit 0 with the carry-in merged in: span 0:0.
    assign pfx_g[0] = bit_pg[0].g | (bit_pg[0].p & cin);

    // Level 1
    ksp_grey_cell u_g1_0 (.upper(bit_pg[1]), .lower_g(pfx_g[0]), .span_g(pfx_g[1]));

    for (genvar i = 3; i < ADDER_W; i++) begin : g_l1
        ksp_black_cell u_blk (.upper(bit_pg[i]), .lower(bit_pg[i-1]), .span(lvl1[i]));
    end
    assign lvl1[0] = '0;
    assign lvl1[1] = '0;
    assign lvl1[2] = '0;

    // Level 2: spans 4:1 and 5:2 pruned. 2:0 and 3:0 both use 1:0 below.
    ksp_grey_cell  u_g2_0 (.upper(bit_pg[2]), .lower_g(pfx_g[1]), .span_g(pfx_g[2]));
    ksp_grey_cell  u_g3_0 (.upper(lvl1[3]),   .lower_g(pfx_g[1]), .span_g(pfx_g[3]));
    ksp_black_cell u_b6_3 (.upper(lvl1[6]),   .lower(lvl1[4]),    .span(span_6_3));
    ksp_black_cell u_b7_4 (.upper(lvl1[7]),   .lower(lvl1[5]),    .span(span_7_4));

    // Level 3: grey cells only, fed from the rerouted spans.
    ksp_grey_cell u_g4_0 (.upper(lvl1[4]),  .lower_g(pfx_g[2]), .span_g(pfx_g[4]));
    ksp_grey_cell u_g5_0 (.upper(lvl1[5]),  .lower_g(pfx_g[3]), .span_g(pfx_g[5]));
    ksp_grey_cell u_g6_0 (.upper(span_6_3), .lower_g(pfx_g[2]), .span_g(pfx_g[6]));
    ksp_grey_cell u_g7_0 (.upper(span_7_4), .lower_g(pfx_g[3]), .span_g(pfx_g[7]));
endmodule

// File: rtl/ksp_post.sv
module ksp_post
    import ksp_pkg::*;
#(
    parameter int W = ADDER_W
) (
    input  pg_t  [W-1:0] bit_pg,
    input  logic [W:0]   carry,
    output logic [W-1:0] sum
);
    for (genvar i = 0; i < W; i++) begin : g_sum
        assign sum[i] = bit_pg[i].p ^ carry[i];
    end
endmodule

// File: rtl/ksp_adder.sv
module ksp_adder
    import ksp_pkg::*;
(
    input  logic [ADDER_W-1:0] op_a,
    input  logic [ADDER_W-1:0] op_b,
    input  logic               cin,
    output logic [ADDER_W-1:0] sum,
    output logic               cout
);
    pg_t  [ADDER_W-1:0] bit_pg;
    logic [ADDER_W-1:0] pfx_g;
    logic [ADDER_W:0]   carry;

    ksp_pre #(.W(ADDER_W)) u_pre (.a_in(op_a), .b_in(op_b), .bit_pg(bit_pg));

    ksp_prefix_net u_net (.bit_pg(bit_pg), .cin(cin), .pfx_g(pfx_g));

    assign carry = {pfx_g, cin};
    assign cout  = carry[ADDER_W];

    ksp_post #(.W(ADDER_W)) u_post (.bit_pg(bit_pg), .carry(carry), .sum(sum));

    logic [ADDER_W:0] ref_total;
    assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{ADDER_W{1'b0}}, cin};

    always_comb begin
        if (!$isunknown({op_a, op_b, cin})) begin
            p_sum_ref_r2: assert (sum == ref_total[ADDER_W-1:0])
                else $error("sum differs from reference");
            p_cout_ref_r3: assert (cout == ref_total[ADDER_W])
                else $error("cout differs from reference");
            p_prop_chain_r5: assert (!(&(op_a ^ op_b)) || (cout == cin))
                else $error("all-propagate did not pass cin");
            for (int i = 0; i < ADDER_W; i++) begin
                p_gen_carry_r6: assert (!(op_a[i] & op_b[i]) || carry[i+1])
                    else $error("generate bit lost its carry");
                p_kill_carry_r7: assert ((op_a[i] | op_b[i]) || !carry[i+1])
                    else $error("kill bit passed a carry");
            end
        end
    end
endmodule

// File: tb/ksp_adder_test.sv
module ksp_adder_test;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic       ci;
        logic [7:0] s;
        logic       co;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'hFE, 8'hFF, 1'b0, 8'hFD, 1'b1},
        '{8'h00, 8'h00, 1'b1, 8'h01, 1'b0},
        '{8'h00, 8'h00, 1'b0, 8'h00, 1'b0},
        '{8'h55, 8'hAA, 1'b0, 8'hFF, 1'b0},
        '{8'h55, 8'hAA, 1'b1, 8'h00, 1'b1},
        '{8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},
        '{8'h80, 8'h80, 1'b0, 8'h00, 1'b1},
        '{8'h0F, 8'h01, 1'b0, 8'h10, 1'b0},
        '{8'h3C, 8'h0C, 1'b1, 8'h49, 1'b0},
        '{8'h7F, 8'h00, 1'b1, 8'h80, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic       cin  = 1'b0;
    logic [7:0] sum;
    logic       cout;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ksp_adder uut (.op_a(op_a), .op_b(op_b), .cin(cin), .sum(sum), .cout(cout));

    task automatic check(input string tag, input logic [7:0] exp_s, input logic exp_c);
        n_checks++;
        if (sum !== exp_s || cout !== exp_c) begin
            n_errors++;
            $display("FAIL %s: a=%h b=%h cin=%b got sum=%h cout=%b expected sum=%h cout=%b",
                     tag, op_a, op_b, cin, sum, cout, exp_s, exp_c);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic c);
        @(posedge clk);
        op_a = a;
        op_b = b;
        cin  = c;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [8:0] tot;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 reset state", 8'h00, 1'b0);
        @(posedge clk);
        rst = 1'b0;

        // Table walk: R9, R4, R5 and mixed patterns (R2, R3)
        for (int k = 0; k < NVEC; k++) begin
            apply(VECS[k].a, VECS[k].b, VECS[k].ci);
            check(k == 0 ? "R9 stated example" : "R2 R3 table vector", VECS[k].s, VECS[k].co);
        end

        // R1: single bit in one operand passes unchanged
        for (int i = 0; i < 8; i++) begin
            apply(8'(1 << i), 8'h00, 1'b0);
            check("R1 single propagate bit", 8'(1 << i), 1'b0);
        end

        // R6: a generating bit carries into the next position
        for (int i = 0; i < 8; i++) begin
            apply(8'(1 << i), 8'(1 << i), 1'b0);
            tot = 9'(2 << i);
            check("R6 generate carries up", tot[7:0], tot[8]);
        end

        // R7: a kill bit blocks a carry produced by the bits below it
        for (int i = 1; i < 8; i++) begin
            apply(8'((1 << i) - 1), 8'((1 << i) - 1), 1'b1);
            tot = 9'((2 << i) - 1);
            check("R7 kill stops carry", tot[7:0], tot[8]);
        end

        // R8: response without any clock edge
        @(negedge clk);
        #2;
        op_a = 8'hC3; op_b = 8'h3D; cin = 1'b0;
        #1;
        check("R8 no clock needed", 8'h00, 1'b1);
        op_a = 8'h12; op_b = 8'h34; cin = 1'b1;
        #1;
        check("R8 no clock needed", 8'h47, 1'b0);

        // R2 R3: every operand and carry-in combination
        for (int v = 0; v < (1 << 17); v++) begin
            @(posedge clk);
            op_a = v[16:9];
            op_b = v[8:1];
            cin  = v[0];
            @(negedge clk);
            tot = {1'b0, op_a} + {1'b0, op_b} + {8'h00, cin};
            check("R2 R3 exhaustive", tot[7:0], tot[8]);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule